// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that sits beside a 10-bit successive-approximation converter. The analog part is not modelled here. A sampled input word stands in for the comparator and DAC, and the block captures that word at the instant a conversion finishes. Software-side writes arrive as single-cycle strobes with their field values. A control write starts, restarts or halts conversions. A configuration write picks the ADC clock source, the prescale ratio and the result format. A read strobe acknowledges the completion flag.

The ADC clock is an enable pulse, not a separate clock. A free-running prescaler counts either bus cycles or one-cycle pulses on the reference-tick input, and it fires when it wraps. Because the prescaler is never realigned to a start write, the first ADC period after a write is partial. For that reason a first conversion spans seventeen enable pulses. A conversion that follows another in continuous mode needs only sixteen. Each finished result is formatted into a high byte and a low byte according to one of four layouts.

The data bytes are plain register outputs and carry no handshake. The last completed result stays on them until the next completion replaces it.

Top module: `adcs_ctrl`

## Requirements
- R1: After reset, `done` and `busy` are 0 and both data bytes read 0.
- R2: A control write with `ctrl_halt`=0 makes `busy` 1 on the following cycle. Its result is delivered on the 17th prescaler pulse after the write edge. Measured in bus cycles from the write edge to the edge that sets `done`, this is between 16*D+1 and 17*D, where D is the prescale ratio. With D=1 it is exactly 17.
- R3: The `cfg_div` codes 0, 1, 2, 3 and 4 give D = 1, 2, 4, 8 and 16. Codes 5 to 7 also give 16. Across write phases, the latency takes both the minimum and the maximum value of R2.
- R4: With `cfg_src`=1 the prescaler counts `ref_tick` pulses instead of bus cycles. With no ref pulses, no conversion finishes.
- R5: `done` is set on the edge where a conversion finishes and stays set until a cycle with `data_rd`=1 and no completion. If a completion and a read fall on the same edge, `done` stays set.
- R6: With `ctrl_cont`=1, conversions repeat every 16*D bus cycles and `busy` stays 1. Each result overwrites the data bytes even if it was never read.
- R7: A control write during a conversion discards that conversion: the data bytes do not change and `done` is not set for it. Timing restarts from the new write.
- R8: A control write with `ctrl_halt`=1 clears `busy` on the next cycle, and no further result arrives.
- R9: Mode 0 (left): `data_hi` = result[9:2], `data_lo` = {result[1:0], 6'b0}.
- R10: Mode 1 (right): `data_hi` = {6'b0, result[9:8]}, `data_lo` = result[7:0].
- R11: Mode 2 (left, signed): as mode 0, but `data_hi` bit 7 is inverted.
- R12: Mode 3 (truncated): `data_hi` = 0, `data_lo` = result[9:2].
- R13: The result is the value of `sample_in` on the completing edge. The data bytes change on no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulses from the external reference clock |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_cont | input | 1 | Continuous-conversion field of the control write |
| ctrl_halt | input | 1 | Halt field of the control write (stop, do not start) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Clock source: 0 bus clock, 1 reference ticks |
| cfg_div | input | 3 | Prescale code |
| cfg_mode | input | 2 | Result format code |
| data_rd | input | 1 | Data read strobe; acknowledges `done` |
| sample_in | input | 10 | Converter result word |
| data_hi | output | 8 | Formatted high byte |
| data_lo | output | 8 | Formatted low byte |
| done | output | 1 | Conversion-complete flag |
| busy | output | 1 | A conversion is in progress |

## Verification
The assertions rely on three input rules. The configuration is written only while no conversion is in progress. `ctrl_wr`, `data_rd` and `ref_tick` are single-cycle pulses. No result can arrive sooner than sixteen prescaler pulses after a write or an earlier result. The bench keeps to these rules: it changes the configuration only after a result or a halt, and it drives every strobe for exactly one cycle at a falling edge. It sweeps every 10-bit sample in every format and every prescale code across all write phases, and the expected bytes and latency bounds come from arithmetic in the bench.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam int RES_W     = 10;
  localparam int REG_W     = 8;
  localparam int PAD_W     = 2 * REG_W - RES_W;
  localparam int DIV_SEL_W = 3;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_LSIGN = 2'd2,
    FMT_TRUNC = 2'd3
  } fmt_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

  typedef struct packed {
    logic [REG_W-1:0] hi;
    logic [REG_W-1:0] lo;
  } result_t;

  function automatic result_t format_result(input logic [RES_W-1:0] r, input fmt_e m);
    result_t o;
    case (m)
      FMT_LEFT:  o = {r, {PAD_W{1'b0}}};
      FMT_RIGHT: o = {{PAD_W{1'b0}}, r};
      FMT_LSIGN: begin
        o = {r, {PAD_W{1'b0}}};
        o.hi[REG_W-1] = ~o.hi[REG_W-1];
      end
      default: begin
        o.hi = '0;
        o.lo = r[RES_W-1 -: REG_W];
      end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/adcs_prescaler.sv
module adcs_prescaler #(
  parameter int DIV_LOG_MAX = 4,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] div_sel,
  output logic             adc_tick
);
  localparam int CNT_W = (DIV_LOG_MAX > 0) ? DIV_LOG_MAX : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             src_tick;
  logic             wrap;

  // terminal count for the selected ratio; codes past the top clamp to it
  always_comb begin
    if (div_sel >= SEL_W'(DIV_LOG_MAX)) limit = '1;
    else                                limit = CNT_W'((32'd1 << div_sel) - 32'd1);
  end

  assign src_tick = src_sel ? ref_tick : 1'b1;
  assign wrap     = (cnt >= limit);
  assign adc_tick = src_tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (src_tick) cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/adcs_seq.sv
module adcs_seq
  import adcs_pkg::*;
#(
  parameter int CYC_FULL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic cont_in,
  input  logic halt_in,
  input  logic adc_tick,
  output logic busy,
  output logic cmpl
);
  localparam int CNT_W = $clog2(CYC_FULL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_FULL);

  sq_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             cont_q;

  assign busy = (state == SQ_RUN);
  // a write in the same cycle wins over a finishing conversion
  assign cmpl = busy && adc_tick && !start_wr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      cont_q <= 1'b0;
    end else if (start_wr) begin
      cnt    <= '0;
      cont_q <= cont_in && !halt_in;
      state  <= halt_in ? SQ_IDLE : SQ_RUN;
    end else if (busy && adc_tick) begin
      if (cnt == LAST) begin
        if (cont_q) begin
          cnt <= CNT_W'(1);      // already aligned: next result needs CYC_FULL pulses
        end else begin
          cnt   <= '0;
          state <= SQ_IDLE;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcs_result.sv
module adcs_result
  import adcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl,
  input  logic             rd,
  input  logic [RES_W-1:0] sample,
  input  fmt_e             mode,
  output logic [REG_W-1:0] hi,
  output logic [REG_W-1:0] lo,
  output logic             done
);
  result_t res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      done  <= 1'b0;
    end else begin
      if (cmpl) res_q <= format_result(sample, mode);
      if (cmpl)    done <= 1'b1;
      else if (rd) done <= 1'b0;
    end
  end

  assign hi = res_q.hi;
  assign lo = res_q.lo;
endmodule

// File: rtl/adcs_ctrl.sv
module adcs_ctrl
  import adcs_pkg::*;
#(
  parameter int CYC_FULL    = 16,
  parameter int DIV_LOG_MAX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_tick,
  input  logic                 ctrl_wr,
  input  logic                 ctrl_cont,
  input  logic                 ctrl_halt,
  input  logic                 cfg_wr,
  input  logic                 cfg_src,
  input  logic [DIV_SEL_W-1:0] cfg_div,
  input  logic [1:0]           cfg_mode,
  input  logic                 data_rd,
  input  logic [RES_W-1:0]     sample_in,
  output logic [REG_W-1:0]     data_hi,
  output logic [REG_W-1:0]     data_lo,
  output logic                 done,
  output logic                 busy
);
  logic                 src_q;
  logic [DIV_SEL_W-1:0] div_q;
  fmt_e                 mode_q;
  logic                 adc_tick;
  logic                 conv_cmpl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      div_q  <= '0;
      mode_q <= FMT_LEFT;
    end else if (cfg_wr) begin
      src_q  <= cfg_src;
      div_q  <= cfg_div;
      mode_q <= fmt_e'(cfg_mode);
    end
  end

  adcs_prescaler #(.DIV_LOG_MAX(DIV_LOG_MAX), .SEL_W(DIV_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_sel(src_q), .ref_tick(ref_tick),
    .div_sel(div_q), .adc_tick(adc_tick)
  );

  adcs_seq #(.CYC_FULL(CYC_FULL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(ctrl_wr), .cont_in(ctrl_cont),
    .halt_in(ctrl_halt), .adc_tick(adc_tick), .busy(busy), .cmpl(conv_cmpl)
  );

  adcs_result u_res (
    .clk(clk), .rst_n(rst_n), .cmpl(conv_cmpl), .rd(data_rd),
    .sample(sample_in), .mode(mode_q), .hi(data_hi), .lo(data_lo), .done(done)
  );
endmodule

// File: rtl/adcs_ctrl_chk.sv
module adcs_ctrl_chk #(
  parameter int CYC_FULL = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic       ctrl_halt,
  input logic       data_rd,
  input logic       cmpl,
  input logic       busy,
  input logic       done,
  input logic [7:0] data_hi,
  input logic [7:0] data_lo
);
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= '0;
    else if (ctrl_wr || cmpl)  gap <= '0;
    else if (gap != 8'hFF)     gap <= gap + 8'd1;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !ctrl_halt |=> busy);

  p_halt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_halt |=> !busy);

  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> done);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !cmpl |=> !done);

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !data_rd |=> done);

  p_abort_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable({data_hi, data_lo}));

  p_data_only_on_cmpl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpl |=> $stable({data_hi, data_lo}));

  p_min_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |-> (gap >= 8'(CYC_FULL - 1)));
endmodule

bind adcs_ctrl adcs_ctrl_chk #(.CYC_FULL(CYC_FULL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_halt(ctrl_halt),
  .data_rd(data_rd), .cmpl(conv_cmpl), .busy(busy), .done(done),
  .data_hi(data_hi), .data_lo(data_lo)
);

// File: tb/adcs_ctrl_tb.sv
module adcs_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick;
  logic       ctrl_wr = 0, ctrl_cont = 0, ctrl_halt = 0;
  logic       cfg_wr = 0, cfg_src = 0;
  logic [2:0] cfg_div = 0;
  logic [1:0] cfg_mode = 0;
  logic       data_rd = 0;
  logic [9:0] sample_in = 0;
  logic [7:0] data_hi, data_lo;
  logic       done, busy;

  int  tests = 0;
  int  fails = 0;
  bit  ended = 0;
  bit  ref_en = 0;
  int  refc = 0;

  always #10 clk = ~clk;

  always @(negedge clk) refc <= (refc == 2) ? 0 : refc + 1;
  assign ref_tick = ref_en && (refc == 2);

  adcs_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ctrl_wr(ctrl_wr),
    .ctrl_cont(ctrl_cont), .ctrl_halt(ctrl_halt), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
    .cfg_div(cfg_div), .cfg_mode(cfg_mode), .data_rd(data_rd), .sample_in(sample_in),
    .data_hi(data_hi), .data_lo(data_lo), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(input int v, input int m);
    case (m)
      0: return v / 4;
      1: return v / 256;
      2: return (v / 4) ^ 128;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_lo(input int v, input int m);
    case (m)
      0, 2: return (v % 4) * 64;
      1: return v % 256;
      default: return v / 4;
    endcase
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      0: return "R9";
      1: return "R10";
      2: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic wr_ctrl(input bit cont, input bit halt);
    @(negedge clk); ctrl_wr = 1; ctrl_cont = cont; ctrl_halt = halt;
    @(negedge clk); ctrl_wr = 0; ctrl_cont = 0; ctrl_halt = 0;
  endtask

  task automatic wr_cfg(input bit src, input int div, input int mode);
    @(negedge clk); cfg_wr = 1; cfg_src = src; cfg_div = 3'(div); cfg_mode = 2'(mode);
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic wait_done(output int lat, input int limit);
    lat = 0;
    while (lat < limit) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  task automatic check_data(input int v, input int m, input string req);
    chk(data_hi == 8'(exp_hi(v, m)), req, int'(data_hi), exp_hi(v, m));
    chk(data_lo == 8'(exp_lo(v, m)), req, int'(data_lo), exp_lo(v, m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lat, dd, mn, mx;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(done == 0, "R1", int'(done), 0);
    chk(busy == 0, "R1", int'(busy), 0);
    chk({data_hi, data_lo} == 16'h0, "R1", int'({data_hi, data_lo}), 0);

    // R9..R12 every sample in every format, bus clock divide by 1; R2 exact latency
    for (int m = 0; m < 4; m++) begin
      wr_cfg(0, 0, m);
      for (int v = 0; v < 1024; v++) begin
        sample_in = 10'(v);
        wr_ctrl(0, 0);
        if (v == 0) chk(busy == 1, "R2", int'(busy), 1);
        wait_done(lat, 40);
        chk(lat == 17, "R2", lat, 17);
        check_data(v, m, mode_req(m));
        rd_pulse();
        chk(done == 0, "R5", int'(done), 0);
      end
    end

    // R3 prescale codes, all write phases; min/max latency
    for (int code = 0; code < 8; code++) begin
      dd = (code >= 4) ? 16 : (1 << code);
      wr_cfg(0, code, 0);
      mn = 100000; mx = 0;
      for (int p = 0; p <= dd; p++) begin
        repeat (p) @(negedge clk);
        wr_ctrl(0, 0);
        wait_done(lat, 400);
        chk(lat >= 16 * dd + 1 && lat <= 17 * dd, "R2", lat, 16 * dd + 1);
        if (p > 0 && lat < mn) mn = lat;
        if (p > 0 && lat > mx) mx = lat;
        rd_pulse();
      end
      chk(mn == 16 * dd + 1, "R3", mn, 16 * dd + 1);
      chk(mx == 17 * dd, "R3", mx, 17 * dd);
    end

    // R4 reference-tick source: ticks every 3 bus cycles, D=1
    wr_cfg(1, 0, 0);
    ref_en = 1;
    wr_ctrl(0, 0);
    wait_done(lat, 200);
    chk(lat >= 49 && lat <= 51, "R4", lat, 49);
    rd_pulse();
    ref_en = 0;
    wr_ctrl(0, 0);
    repeat (100) @(negedge clk);
    chk(done == 0, "R4", int'(done), 0);
    chk(busy == 1, "R4", int'(busy), 1);
    ref_en = 1;
    wait_done(lat, 200);
    chk(done == 1, "R4", int'(done), 1);
    rd_pulse();
    ref_en = 0;

    // R6 continuous mode, D=2, right-justified
    wr_cfg(0, 1, 1);
    sample_in = 10'd100;
    wr_ctrl(1, 0);
    wait_done(lat, 100);
    chk(lat >= 33 && lat <= 34, "R6", lat, 33);
    data_rd = 1;
    @(negedge clk); data_rd = 0;
    wait_done(lat, 100);
    chk(lat + 1 == 32, "R6", lat + 1, 32);
    check_data(100, 1, "R6");
    sample_in = 10'd200;
    repeat (32) @(negedge clk);
    check_data(200, 1, "R6");
    chk(done == 1, "R6", int'(done), 1);
    chk(busy == 1, "R6", int'(busy), 1);

    // R8 halt
    wr_ctrl(0, 1);
    chk(busy == 0, "R8", int'(busy), 0);
    rd_pulse();
    held = {data_hi, data_lo};
    repeat (80) @(negedge clk);
    chk({data_hi, data_lo} == held, "R8", int'({data_hi, data_lo}), int'(held));
    chk(done == 0 && busy == 0, "R8", int'({done, busy}), 0);

    // R7 abort by a second write mid-conversion, D=1
    wr_cfg(0, 0, 1);
    sample_in = 10'd5;
    wr_ctrl(0, 0);
    repeat (10) @(negedge clk);
    sample_in = 10'd7;
    wr_ctrl(0, 0);
    repeat (10) @(negedge clk);
    chk(done == 0, "R7", int'(done), 0);
    chk({data_hi, data_lo} == held, "R7", int'({data_hi, data_lo}), int'(held));
    wait_done(lat, 40);
    chk(lat + 10 == 17, "R7", lat + 10, 17);
    check_data(7, 1, "R7");
    rd_pulse();

    // R5 read on the completing edge; R13 capture on that edge
    sample_in = 10'd11;
    wr_ctrl(0, 0);
    repeat (16) @(negedge clk);
    sample_in = 10'd22;
    data_rd = 1;
    @(negedge clk);
    data_rd = 0;
    sample_in = 10'd33;
    chk(done == 1, "R5", int'(done), 1);
    check_data(22, 1, "R13");
    repeat (3) @(negedge clk);
    check_data(22, 1, "R13");
    rd_pulse();
    chk(done == 0, "R5", int'(done), 0);

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule